// File: doc/BRIEF.md
# Load/Store Lane Alignment and Extension Unit

This unit sits between the load/store stage of a processor and a data memory that is 32 bits wide and addressed by word. A request carries a byte address, an access size (byte, halfword or word), a signed/unsigned flag, a load/store select, store data and a byte-order select. From these, the unit produces the memory word address, a request strobe, per-lane write strobes and lane-steered store data. The same cycle, it raises a misalignment flag when the address does not suit the size.

Loads are serviced by a memory with a one-cycle synchronous read. The unit registers the offset, size, sign flag and byte order of each load. One cycle later it selects the addressed byte or halfword from the returned word and sign- or zero-extends it to 32 bits. Both byte orders are supported per request. In little-endian order the lowest address holds the least significant byte. In big-endian order the lowest address holds the most significant byte. The unit does no arithmetic on data beyond steering and extension.

Top module: `lsu_lane_align`

## Requirements
- R1: A request with size code 2'b10 (word) or 2'b11 (also treated as word) whose byte address has a nonzero low two bits raises `misalign` in the same cycle while `req_valid` is high.
- R2: A halfword request (size 2'b01) raises `misalign` exactly when address bit 0 is 1. A byte request (size 2'b00) never raises it.
- R3: A misaligned request keeps `mem_req` low and all `mem_wstrb` bits low. If it is a load, the next cycle shows `ld_valid` high with `ld_data` equal to zero.
- R4: `mem_addr` equals the byte address shifted right by two.
- R5: Memory lane L is `mem_wdata[8L+7:8L]`. Byte offset o maps to lane o in little-endian mode (`big_endian`=0) and to lane 3-o in big-endian mode. An aligned store sets exactly the strobes of the lanes it covers: 1, 2 or 4 for byte, halfword or word.
- R6: In big-endian mode, the most significant byte of the store data goes to the lowest covered address. In little-endian mode, the least significant byte goes there.
- R7: A byte store replicates data bits 7:0 into all four lanes. A halfword store replicates bits 15:0 into both lane pairs.
- R8: A load returns its result one cycle after the request, with `ld_valid` high. The result is taken from the addressed lanes under the byte order given with the request. Loads never set any write strobe.
- R9: A signed byte or halfword load is sign-extended to 32 bits.
- R10: An unsigned byte or halfword load is zero-extended to 32 bits. A word load returns the assembled word unchanged.
- R11: During and after reset, with no load pending, `ld_valid` and `ld_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_signed | input | 1 | Sign-extend partial loads |
| req_store | input | 1 | 1 store, 0 load |
| req_wdata | input | 32 | Store data, right-aligned |
| big_endian | input | 1 | Byte order of this request |
| mem_req | output | 1 | Aligned request to memory |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wstrb | output | 4 | Per-lane write strobes |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_rdata | input | 32 | Read word, one cycle after mem_req |
| misalign | output | 1 | Request address does not suit its size |
| ld_valid | output | 1 | Load result present |
| ld_data | output | 32 | Extracted, extended load result |

## Verification
Two functions can fall in the same cycle: a load's extraction and extension, and a following store's lane steering. When a store directly follows a load, the load result appears on `ld_data` in the same cycle that the store's strobes and data are on the memory side. The bench issues a load with one byte order and, on the next cycle, a store with the opposite order and a different offset. It then compares the load result against the value computed from the preloaded word. In the same sample, it compares the store's strobes and lane data against the values computed for the store, so that any leak of one request's registered context into the other's path shows up.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = BYTE_W * LANES;
    localparam int OFF_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic             valid;
        logic             misal;
        acc_size_e        size;
        logic [OFF_W-1:0] off;
        logic             sgn;
        logic             big;
    } ld_ctx_t;

endpackage

// File: rtl/lsu_align_check.sv
module lsu_align_check
    import lsu_lane_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] off,
    output logic             misal
);

    always_comb begin
        unique case (acc_size_e'(size))
            SZ_BYTE: misal = 1'b0;
            SZ_HALF: misal = off[0];
            default: misal = |off;
        endcase
    end

endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
    import lsu_lane_pkg::*;
(
    input  logic              enable,
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  off,
    input  logic              big,
    input  logic [WORD_W-1:0] wdata,
    output logic [LANES-1:0]  strb,
    output logic [WORD_W-1:0] lane_data
);

    logic [OFF_W-1:0] byte_lane;
    logic [OFF_W-1:0] half_lo;
    logic [LANES-1:0] mask;

    always_comb begin
        byte_lane = big ? ~off : off;
        half_lo   = big ? {~off[1], 1'b0} : {off[1], 1'b0};
        unique case (acc_size_e'(size))
            SZ_BYTE: mask = LANES'(1) << byte_lane;
            SZ_HALF: mask = LANES'(3) << half_lo;
            default: mask = '1;
        endcase
        strb = enable ? mask : '0;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_comb begin
            unique case (acc_size_e'(size))
                SZ_BYTE: lane_data[l*BYTE_W +: BYTE_W] = wdata[BYTE_W-1:0];
                SZ_HALF: lane_data[l*BYTE_W +: BYTE_W] = wdata[(l%2)*BYTE_W +: BYTE_W];
                default: lane_data[l*BYTE_W +: BYTE_W] = wdata[l*BYTE_W +: BYTE_W];
            endcase
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_lane_pkg::*;
(
    input  ld_ctx_t           ctx,
    input  logic [WORD_W-1:0] rdata,
    output logic [WORD_W-1:0] result
);

    logic [OFF_W-1:0]    byte_lane;
    logic [OFF_W-1:0]    half_lo;
    logic [BYTE_W-1:0]   b_sel;
    logic [2*BYTE_W-1:0] h_sel;

    always_comb begin
        byte_lane = ctx.big ? ~ctx.off : ctx.off;
        half_lo   = ctx.big ? {~ctx.off[1], 1'b0} : {ctx.off[1], 1'b0};
        b_sel     = rdata[byte_lane*BYTE_W +: BYTE_W];
        h_sel     = rdata[half_lo*BYTE_W +: 2*BYTE_W];
        if (!ctx.valid || ctx.misal) begin
            result = '0;
        end else begin
            unique case (ctx.size)
                SZ_BYTE: result = {{(WORD_W-BYTE_W){ctx.sgn & b_sel[BYTE_W-1]}}, b_sel};
                SZ_HALF: result = {{(WORD_W-2*BYTE_W){ctx.sgn & h_sel[2*BYTE_W-1]}}, h_sel};
                default: result = rdata;
            endcase
        end
    end

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
    import lsu_lane_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic              req_store,
    input  logic [31:0]       req_wdata,
    input  logic              big_endian,
    output logic              mem_req,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [3:0]        mem_wstrb,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              misalign,
    output logic              ld_valid,
    output logic [31:0]       ld_data
);

    localparam int WADDR_W = ADDR_W - OFF_W;

    logic             misal_raw;
    logic [OFF_W-1:0] off;
    ld_ctx_t          ctx_d;
    ld_ctx_t          ctx_q;

    assign off = req_addr[OFF_W-1:0];

    lsu_align_check u_align (
        .size  (req_size),
        .off   (off),
        .misal (misal_raw)
    );

    lsu_store_steer u_steer (
        .enable    (req_valid && req_store && !misal_raw),
        .size      (req_size),
        .off       (off),
        .big       (big_endian),
        .wdata     (req_wdata),
        .strb      (mem_wstrb),
        .lane_data (mem_wdata)
    );

    lsu_load_extract u_extract (
        .ctx    (ctx_q),
        .rdata  (mem_rdata),
        .result (ld_data)
    );

    assign misalign = req_valid && misal_raw;
    assign mem_req  = req_valid && !misal_raw;
    assign mem_addr = req_addr[ADDR_W-1 -: WADDR_W];
    assign ld_valid = ctx_q.valid;

    always_comb begin
        ctx_d       = ctx_q;
        ctx_d.valid = req_valid && !req_store;
        if (req_valid && !req_store) begin
            ctx_d.misal = misal_raw;
            ctx_d.size  = acc_size_e'(req_size);
            ctx_d.off   = off;
            ctx_d.sgn   = req_signed;
            ctx_d.big   = big_endian;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{valid: 1'b0, misal: 1'b0, size: SZ_BYTE, off: '0, sgn: 1'b0, big: 1'b0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assert_word_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size[1] && (off != 2'b00)) |-> misalign);

    assert_byte_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b00) |-> !misalign);

    assert_misal_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        misalign |-> (mem_wstrb == 4'b0000 && !mem_req));

    assert_misal_zero_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (misalign && !req_store) |=> (ld_valid && ld_data == 32'd0));

    assert_strb_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && !misalign) |->
        ($countones(mem_wstrb) == (req_size == 2'b00 ? 1 : (req_size == 2'b01 ? 2 : 4))));

    assert_load_no_strb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store) |-> (mem_wstrb == 4'b0000));

    assert_sign_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ctx_q.sgn && ctx_q.size == SZ_BYTE && !ctx_q.misal) |->
        (ld_data[31:8] == {24{ld_data[7]}}));

    assert_zero_half_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ctx_q.sgn && ctx_q.size == SZ_HALF) |-> (ld_data[31:16] == 16'd0));

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |-> (ld_data == 32'd0));

endmodule

// File: tb/tb_lsu_lane_align.sv
module tb_lsu_lane_align;

    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [1:0]        req_size = 2'b00;
    logic              req_signed = 1'b0;
    logic              req_store = 1'b0;
    logic [31:0]       req_wdata = '0;
    logic              big_endian = 1'b0;
    logic              mem_req;
    logic [ADDR_W-3:0] mem_addr;
    logic [3:0]        mem_wstrb;
    logic [31:0]       mem_wdata;
    logic [31:0]       mem_rdata = '0;
    logic              misalign;
    logic              ld_valid;
    logic [31:0]       ld_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [31:0] mem_w [0:15];

    always #4 clk = ~clk;

    lsu_lane_align #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_signed(req_signed), .req_store(req_store),
        .req_wdata(req_wdata), .big_endian(big_endian), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .misalign(misalign), .ld_valid(ld_valid),
        .ld_data(ld_data)
    );

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_wstrb != 4'b0000) begin
                for (int l = 0; l < 4; l++)
                    if (mem_wstrb[l]) mem_w[mem_addr[3:0]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
            end else begin
                mem_rdata <= mem_w[mem_addr[3:0]];
            end
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            fails  = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int lane_of(input int o, input bit be);
        return be ? 3 - o : o;
    endfunction

    function automatic int nbytes(input int sz);
        return sz == 0 ? 1 : (sz == 1 ? 2 : 4);
    endfunction

    function automatic bit legal(input int sz, input int o);
        return sz == 0 ? 1'b1 : (sz == 1 ? (o % 2 == 0) : (o == 0));
    endfunction

    function automatic logic [31:0] exp_load(input logic [31:0] w, input int sz, input int o,
                                            input bit sg, input bit be);
        logic [31:0] v = '0;
        int n = nbytes(sz);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = w[lane_of(o + i, be)*8 +: 8];
            if (be) v[(n-1-i)*8 +: 8] = b;
            else    v[i*8 +: 8] = b;
        end
        if (sg && n < 4 && v[n*8-1]) for (int k = n*8; k < 32; k++) v[k] = 1'b1;
        return v;
    endfunction

    task automatic drive(input bit v, input int addr, input int sz, input bit sg,
                         input bit st, input logic [31:0] d, input bit be);
        req_valid = v; req_addr = ADDR_W'(addr); req_size = 2'(sz);
        req_signed = sg; req_store = st; req_wdata = d; big_endian = be;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_reset();
        #1;
        chk(ld_valid == 1'b0, "R11 ld_valid in reset", 32'(ld_valid), 0);
        chk(ld_data == 32'd0, "R11 ld_data in reset", ld_data, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        chk(ld_valid == 1'b0, "R11 ld_valid idle", 32'(ld_valid), 0);
        chk(ld_data == 32'd0, "R11 ld_data idle", ld_data, 0);
    endtask

    task automatic t_misalign();
        for (int sz = 0; sz < 4; sz++) begin
            for (int o = 0; o < 4; o++) begin
                bit bad = !legal(sz > 2 ? 2 : sz, o);
                @(negedge clk); drive(1, 32 + o, sz, 1, 1, 32'hFFFF_FFFF, o[0]); #1;
                chk(misalign == bad, sz >= 2 ? "R1 word alignment" : "R2 half/byte alignment",
                    32'(misalign), 32'(bad));
                if (bad) begin
                    chk(mem_wstrb == 4'b0 && !mem_req, "R3 misaligned store quiet",
                        {mem_req, 27'b0, mem_wstrb}, 0);
                    @(negedge clk); drive(1, 32 + o, sz, 1, 0, 0, 0); #1;
                    chk(!mem_req, "R3 misaligned load no request", 32'(mem_req), 0);
                    @(negedge clk); idle(); #1;
                    chk(ld_valid && ld_data == 0, "R3 misaligned load zero", ld_data, 0);
                end
            end
        end
        @(negedge clk); idle();
    endtask

    task automatic t_store_lanes();
        for (int be = 0; be < 2; be++) begin
            for (int sz = 0; sz < 3; sz++) begin
                for (int o = 0; o < 4; o++) begin
                    if (legal(sz, o)) begin
                        logic [31:0] d = 32'hC3A5_5A00 ^ {8'(sz), 8'(o), 8'(be), 8'(o*17 + 3)};
                        int n = nbytes(sz);
                        int wa = 3 + be*4 + sz;
                        logic [3:0] es = '0;
                        for (int i = 0; i < n; i++) es[lane_of(o + i, bit'(be))] = 1'b1;
                        @(negedge clk); mem_w[wa] = 32'h0;
                        drive(1, wa*4 + o, sz, 0, 1, d, bit'(be)); #1;
                        chk(mem_addr == (ADDR_W-2)'(wa), "R4 word address", 32'(mem_addr), wa);
                        chk(mem_wstrb == es, "R5 store strobes", 32'(mem_wstrb), 32'(es));
                        for (int i = 0; i < n; i++) begin
                            logic [7:0] eb = be ? d[(n-1-i)*8 +: 8] : d[i*8 +: 8];
                            chk(mem_wdata[lane_of(o + i, bit'(be))*8 +: 8] == eb, "R6 store byte order",
                                32'(mem_wdata[lane_of(o + i, bit'(be))*8 +: 8]), 32'(eb));
                        end
                        if (sz == 0) chk(mem_wdata == {4{d[7:0]}}, "R7 byte replication", mem_wdata, {4{d[7:0]}});
                        if (sz == 1) chk(mem_wdata == {2{d[15:0]}}, "R7 half replication", mem_wdata, {2{d[15:0]}});
                        @(negedge clk); drive(1, wa*4 + o, sz, 0, 0, 0, bit'(be)); #1;
                        chk(mem_wstrb == 4'b0, "R8 load no strobe", 32'(mem_wstrb), 0);
                        @(negedge clk); idle(); #1;
                        chk(ld_valid && ld_data == (n == 4 ? d : d & ((32'd1 << (n*8)) - 1)),
                            "R10 store-load round trip", ld_data, d);
                    end
                end
            end
        end
    endtask

    task automatic t_load_extract();
        logic [31:0] w = 32'h8142_F364;
        @(negedge clk); mem_w[9] = w;
        for (int be = 0; be < 2; be++)
            for (int sz = 0; sz < 3; sz++)
                for (int o = 0; o < 4; o++)
                    for (int sg = 0; sg < 2; sg++)
                        if (legal(sz, o)) begin
                            logic [31:0] e = exp_load(w, sz, o, bit'(sg), bit'(be));
                            @(negedge clk); drive(1, 36 + o, sz, bit'(sg), 0, 0, bit'(be));
                            @(negedge clk); idle(); #1;
                            chk(ld_valid && ld_data == e,
                                sz == 2 ? "R10 word load" : (sg ? "R9 signed load" : "R10 unsigned load"),
                                ld_data, e);
                            chk(ld_valid, "R8 load latency", 32'(ld_valid), 1);
                        end
    endtask

    task automatic t_load_then_store();
        logic [31:0] w = 32'h7E9C_02B1;
        logic [31:0] e = exp_load(w, 1, 2, 1'b1, 1'b1);
        @(negedge clk); mem_w[10] = w;
        drive(1, 40 + 2, 1, 1, 0, 0, 1);
        @(negedge clk); drive(1, 44 + 1, 0, 0, 1, 32'h0000_00D7, 0); #1;
        chk(ld_valid && ld_data == e, "R8 load beside store", ld_data, e);
        chk(mem_wstrb == 4'b0010, "R5 store beside load", 32'(mem_wstrb), 32'h2);
        chk(mem_wdata[15:8] == 8'hD7, "R7 store data beside load", 32'(mem_wdata[15:8]), 32'hD7);
        @(negedge clk); idle(); #1;
        chk(!ld_valid && ld_data == 0, "R11 idle after store", ld_data, 0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem_w[i] = 32'h0;
        t_reset();
        t_misalign();
        t_store_lanes();
        t_load_extract();
        t_load_then_store();
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule